// File: doc/BRIEF.md
# Triggered Window Capture Buffer

The block keeps a running history of a wide trigger-data word, storing one sample on every clock into a circular history memory. When a level-1 trigger is seen, a free event slot is claimed. That slot copies a window of consecutive samples out of the history. The window begins a fixed number of clocks before the sample taken with the trigger and is a fixed number of clocks long.

Several slots may copy at the same time, so triggers that arrive on neighbouring clocks are all kept. A byte serializer empties the filled slots in the order their triggers arrived. For each event it sends a short header and then the payload, and it raises a write strobe and a header flag beside the data.

Suppress mode is not a separate circuit. It is the same block built with a window of one clock, usually with zero delay. Each event then carries a single sample, so the history memory and the slot storage both shrink.

Top module: `twc_capture`

## Requirements
- R1: After reset, `ser_we_o`, `ser_pause_o` and `busy_o` are low and `drop_cnt_o` is zero.
- R2: The payload of an event holds WIN samples. The first is the sample taken DELAY clocks before the trigger sample, and later samples follow in capture order. Each sample is sent least significant byte first.
- R3: The header has 4 bytes: the 16-bit event number (low byte, then high byte), then the 16-bit window length WIN (low byte, then high byte). Event numbers count accepted triggers from 0 after reset.
- R4: Each event occupies 4 + WIN*SAMPLE_W/8 consecutive cycles with `ser_we_o` high. `ser_pause_o` is high on exactly the 4 header cycles and low on every payload cycle. `ser_we_o` is low whenever no event byte is present.
- R5: Triggers on up to NBUF consecutive clocks are each captured into their own slot, with correct windows.
- R6: Events leave the serializer in the order their triggers arrived.
- R7: `busy_o` is high while every slot is occupied. A trigger seen while `busy_o` is high is discarded and increments `drop_cnt_o`. It produces no event and does not alter any stored event.
- R8: Once the oldest event has been fully sent, `busy_o` falls and the next trigger is accepted with the next event number.
- R9: With WIN = 1 and DELAY = 0 (suppress mode), each event carries exactly the one sample taken on the trigger clock, with 1 as the header window field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | SAMPLE_W | Trigger-data word, stored every clock |
| trig_i | input | 1 | Level-1 trigger, one clock per trigger |
| ser_data_o | output | 8 | Serialized header or payload byte |
| ser_we_o | output | 1 | High when `ser_data_o` holds a valid byte |
| ser_pause_o | output | 1 | High on header bytes, low on payload bytes |
| busy_o | output | 1 | All event slots occupied; a trigger now is dropped |
| drop_cnt_o | output | 16 | Number of dropped triggers, wrapping |

## Verification
Several things can fall in the same clock: a new trigger claims a slot, other slots copy from the history, and the serializer reads a finished slot. The hardest case is a burst of triggers on consecutive clocks while the serializer is still busy. The burst is made one longer than the number of slots, so the last trigger meets a full block and must be dropped. The result is judged only at the byte stream and the status ports: the windows must be exact, event numbers must rise in order, no extra event may appear, and the drop count must rise by one. A further trigger is then sent right after the oldest slot is freed, and it must come out after the events already waiting.

// File: rtl/twc_pkg.sv
package twc_pkg;
    typedef enum logic [1:0] {SLOT_FREE, SLOT_FILL, SLOT_READY} slot_st_e;
    typedef enum logic [1:0] {SER_IDLE, SER_HDR, SER_PAY} ser_st_e;
    localparam int HDR_BYTES = 4;
    localparam int EVT_W     = 16;
endpackage

// File: rtl/twc_ring.sv
// Circular history: one write per clock, one combinational read port per slot.
module twc_ring #(
    parameter int SAMPLE_W = 32,
    parameter int DEPTH    = 64,
    parameter int NRD      = 4,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SAMPLE_W-1:0]           din_i,
    output logic [AW-1:0]                 wptr_o,
    input  logic [NRD-1:0][AW-1:0]        rd_addr_i,
    output logic [NRD-1:0][SAMPLE_W-1:0]  rd_data_o
);
    typedef struct packed {
        logic [AW-1:0] wp;
    } ring_st_t;

    ring_st_t q, d;
    logic [SAMPLE_W-1:0] mem [DEPTH];

    always_comb begin
        d    = q;
        d.wp = q.wp + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        mem[q.wp] <= din_i;
    end

    assign wptr_o = q.wp;

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data_o[g] = mem[rd_addr_i[g]];
    end
endmodule

// File: rtl/twc_evbuf.sv
// Event slots: allocation on trigger, parallel window copy, in-order release.
module twc_evbuf import twc_pkg::*; #(
    parameter int SAMPLE_W = 32,
    parameter int WIN      = 24,
    parameter int DELAY    = 11,
    parameter int DEPTH    = 64,
    parameter int NBUF     = 4,
    localparam int AW      = $clog2(DEPTH),
    localparam int WW      = (WIN > 1) ? $clog2(WIN) : 1,
    localparam int CW      = $clog2(WIN + 1),
    localparam int SW      = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int EAW     = (NBUF * WIN > 1) ? $clog2(NBUF * WIN) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          trig_i,
    input  logic [AW-1:0]                 ring_wp_i,
    output logic [NBUF-1:0][AW-1:0]       ring_addr_o,
    input  logic [NBUF-1:0][SAMPLE_W-1:0] ring_data_i,
    output logic                          head_ready_o,
    output logic [EVT_W-1:0]              head_evt_o,
    input  logic [WW-1:0]                 word_idx_i,
    output logic [SAMPLE_W-1:0]           word_o,
    input  logic                          release_i,
    output logic                          busy_o,
    output logic [15:0]                   drop_cnt_o
);
    typedef struct packed {
        slot_st_e [NBUF-1:0]          st;
        logic [NBUF-1:0][AW-1:0]      start;
        logic [NBUF-1:0][CW-1:0]      cnt;
        logic [NBUF-1:0][EVT_W-1:0]   evt;
        logic [SW-1:0]                wr;
        logic [SW-1:0]                rd;
        logic [EVT_W-1:0]             evt_ctr;
        logic [15:0]                  drop;
    } slot_ctl_t;

    slot_ctl_t q, d;
    logic [SAMPLE_W-1:0] store [NBUF*WIN];
    logic                full;

    function automatic logic [SW-1:0] slot_next(input logic [SW-1:0] p);
        return (p == SW'(NBUF - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d    = q;
        full = (q.st[q.wr] != SLOT_FREE);
        for (int i = 0; i < NBUF; i++) begin
            if (q.st[i] == SLOT_FILL) begin
                d.cnt[i] = q.cnt[i] + 1'b1;
                if (q.cnt[i] == CW'(WIN - 1)) d.st[i] = SLOT_READY;
            end
        end
        if (release_i) begin
            d.st[q.rd] = SLOT_FREE;
            d.rd       = slot_next(q.rd);
        end
        if (trig_i) begin
            if (full) begin
                d.drop = q.drop + 1'b1;
            end else begin
                d.st[q.wr]    = SLOT_FILL;
                d.start[q.wr] = ring_wp_i - AW'(DELAY);
                d.cnt[q.wr]   = '0;
                d.evt[q.wr]   = q.evt_ctr;
                d.evt_ctr     = q.evt_ctr + 1'b1;
                d.wr          = slot_next(q.wr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_fill
        assign ring_addr_o[g] = q.start[g] + AW'(q.cnt[g]);
        always_ff @(posedge clk) begin
            if (q.st[g] == SLOT_FILL)
                store[EAW'(g * WIN) + EAW'(q.cnt[g])] <= ring_data_i[g];
        end
    end

    assign word_o       = store[EAW'(q.rd) * EAW'(WIN) + EAW'(word_idx_i)];
    assign head_ready_o = (q.st[q.rd] == SLOT_READY);
    assign head_evt_o   = q.evt[q.rd];
    assign busy_o       = full;
    assign drop_cnt_o   = q.drop;
endmodule

// File: rtl/twc_ser.sv
// Byte serializer: 4 header bytes then WIN samples, LSB byte first.
module twc_ser import twc_pkg::*; #(
    parameter int SAMPLE_W = 32,
    parameter int WIN      = 24,
    localparam int BPS     = SAMPLE_W / 8,
    localparam int WW      = (WIN > 1) ? $clog2(WIN) : 1,
    localparam int BSW     = (BPS > 1) ? $clog2(BPS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                head_ready_i,
    input  logic [EVT_W-1:0]    head_evt_i,
    input  logic [SAMPLE_W-1:0] word_i,
    output logic [WW-1:0]       word_idx_o,
    output logic                release_o,
    output logic [7:0]          data_o,
    output logic                we_o,
    output logic                pause_o
);
    typedef struct packed {
        ser_st_e      st;
        logic [1:0]   hcnt;
        logic [WW-1:0] widx;
        logic [BSW-1:0] bsel;
        logic [7:0]   out;
        logic         we;
        logic         pause;
    } ser_t;

    ser_t q, d;
    logic [31:0] hdr_word;

    assign hdr_word = {16'(WIN), head_evt_i};

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        d.pause   = 1'b0;
        release_o = 1'b0;
        case (q.st)
            SER_IDLE: begin
                if (head_ready_i) begin
                    d.st   = SER_HDR;
                    d.hcnt = '0;
                end
            end
            SER_HDR: begin
                d.we    = 1'b1;
                d.pause = 1'b1;
                d.out   = hdr_word[{q.hcnt, 3'b000} +: 8];
                if (q.hcnt == 2'(HDR_BYTES - 1)) begin
                    d.st   = SER_PAY;
                    d.widx = '0;
                    d.bsel = '0;
                end else begin
                    d.hcnt = q.hcnt + 1'b1;
                end
            end
            SER_PAY: begin
                d.we  = 1'b1;
                d.out = word_i[{q.bsel, 3'b000} +: 8];
                if (q.bsel == BSW'(BPS - 1)) begin
                    d.bsel = '0;
                    if (q.widx == WW'(WIN - 1)) begin
                        d.st      = SER_IDLE;
                        release_o = 1'b1;
                    end else begin
                        d.widx = q.widx + 1'b1;
                    end
                end else begin
                    d.bsel = q.bsel + 1'b1;
                end
            end
            default: d.st = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_idx_o = q.widx;
    assign data_o     = q.out;
    assign we_o       = q.we;
    assign pause_o    = q.pause;
endmodule

// File: rtl/twc_capture.sv
module twc_capture import twc_pkg::*; #(
    parameter int SAMPLE_W = 32,
    parameter int WIN      = 24,
    parameter int DELAY    = 11,
    parameter int DEPTH    = 64,
    parameter int NBUF     = 4,
    localparam int AW      = $clog2(DEPTH),
    localparam int WW      = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                trig_i,
    output logic [7:0]          ser_data_o,
    output logic                ser_we_o,
    output logic                ser_pause_o,
    output logic                busy_o,
    output logic [15:0]         drop_cnt_o
);
    if (DELAY + WIN >= DEPTH) begin : g_bad_depth
        $error("history depth must exceed delay plus window");
    end
    if ((1 << AW) != DEPTH) begin : g_bad_pow2
        $error("history depth must be a power of two");
    end
    if ((SAMPLE_W % 8) != 0 || WIN < 1 || NBUF < 1) begin : g_bad_shape
        $error("sample width must be whole bytes, window and slots nonzero");
    end

    logic [AW-1:0]                 ring_wp;
    logic [NBUF-1:0][AW-1:0]       ring_addr;
    logic [NBUF-1:0][SAMPLE_W-1:0] ring_data;
    logic                          head_ready;
    logic [EVT_W-1:0]              head_evt;
    logic [WW-1:0]                 word_idx;
    logic [SAMPLE_W-1:0]           word;
    logic                          rel;

    twc_ring #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .NRD(NBUF)) u_ring (
        .clk(clk), .rst_n(rst_n), .din_i(sample_i), .wptr_o(ring_wp),
        .rd_addr_i(ring_addr), .rd_data_o(ring_data)
    );

    twc_evbuf #(.SAMPLE_W(SAMPLE_W), .WIN(WIN), .DELAY(DELAY), .DEPTH(DEPTH),
                .NBUF(NBUF)) u_evbuf (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .ring_wp_i(ring_wp),
        .ring_addr_o(ring_addr), .ring_data_i(ring_data),
        .head_ready_o(head_ready), .head_evt_o(head_evt),
        .word_idx_i(word_idx), .word_o(word), .release_i(rel),
        .busy_o(busy_o), .drop_cnt_o(drop_cnt_o)
    );

    twc_ser #(.SAMPLE_W(SAMPLE_W), .WIN(WIN)) u_ser (
        .clk(clk), .rst_n(rst_n), .head_ready_i(head_ready),
        .head_evt_i(head_evt), .word_i(word), .word_idx_o(word_idx),
        .release_o(rel), .data_o(ser_data_o), .we_o(ser_we_o),
        .pause_o(ser_pause_o)
    );
endmodule

// File: rtl/twc_capture_chk.sv
module twc_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        trig_i,
    input logic        ser_we_o,
    input logic        ser_pause_o,
    input logic        busy_o,
    input logic [15:0] drop_cnt_o
);
    AST_PAUSE_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ser_pause_o |-> ser_we_o); // R4
    AST_EVENT_OPENS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_we_o) |-> ser_pause_o); // R4
    AST_HDR_INTO_PAY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_pause_o) |-> ser_we_o); // R4
    AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && busy_o) |=> drop_cnt_o == 16'($past(drop_cnt_o) + 16'd1)); // R7
    AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_i && busy_o) |=> $stable(drop_cnt_o)); // R7
endmodule

bind twc_capture twc_capture_chk u_chk (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .ser_we_o(ser_we_o),
    .ser_pause_o(ser_pause_o), .busy_o(busy_o), .drop_cnt_o(drop_cnt_o)
);

// File: tb/twc_capture_tb.sv
`timescale 1ns/1ps
module twc_capture_tb;
    localparam int SW = 32;
    localparam int WA = 24, DA = 11;
    localparam int WS = 1,  DS = 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [SW-1:0] din = '0;
    logic        trig_a = 1'b0, trig_s = 1'b0;
    logic [7:0]  a_data, s_data;
    logic        a_we, a_pause, a_busy, s_we, s_pause, s_busy;
    logic [15:0] a_drop, s_drop;

    int n_chk = 0, n_bad = 0, scnt = 0, cyc = 0;
    byte unsigned a_b[$], s_b[$];
    bit  a_p[$], s_p[$];
    int  a_c[$], s_c[$];

    always #5 clk = ~clk;

    twc_capture #(.SAMPLE_W(SW), .WIN(WA), .DELAY(DA), .DEPTH(64), .NBUF(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .sample_i(din), .trig_i(trig_a),
        .ser_data_o(a_data), .ser_we_o(a_we), .ser_pause_o(a_pause),
        .busy_o(a_busy), .drop_cnt_o(a_drop));

    twc_capture #(.SAMPLE_W(SW), .WIN(WS), .DELAY(DS), .DEPTH(4), .NBUF(4)) u_sup (
        .clk(clk), .rst_n(rst_n), .sample_i(din), .trig_i(trig_s),
        .ser_data_o(s_data), .ser_we_o(s_we), .ser_pause_o(s_pause),
        .busy_o(s_busy), .drop_cnt_o(s_drop));

    always @(negedge clk) begin
        cyc++;
        if (a_we) begin a_b.push_back(a_data); a_p.push_back(a_pause); a_c.push_back(cyc); end
        if (s_we) begin s_b.push_back(s_data); s_p.push_back(s_pause); s_c.push_back(cyc); end
    end

    function automatic logic [31:0] pat(input int n);
        return {16'(n), 16'(n * 37 + 5)};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Drive one clock; returns the sample index captured at the coming edge.
    task automatic tick(input bit ta, input bit ts, output int s);
        @(negedge clk);
        din = pat(scnt); trig_a = ta; trig_s = ts;
        s = scnt; scnt++;
    endtask

    task automatic idle(input int n);
        int s;
        for (int i = 0; i < n; i++) tick(0, 0, s);
    endtask

    function automatic int qsize(input bit sup);
        return sup ? s_b.size() : a_b.size();
    endfunction

    task automatic expect_event(input bit sup, input int evt, input int first,
                                input int win, input string rq);
        int n = 4 + win * 4;
        int guard = 0;
        int pbad = 0;
        int c0 = 0, cl = 0, s;
        byte unsigned b[$];
        bit pz;
        while (qsize(sup) < n && guard < 3000) begin tick(0, 0, s); guard++; end
        chk(qsize(sup) >= n, rq, "event bytes arrived", qsize(sup), n);
        if (qsize(sup) < n) return;
        for (int k = 0; k < n; k++) begin
            if (sup) begin b.push_back(s_b.pop_front()); pz = s_p.pop_front(); cl = s_c.pop_front(); end
            else     begin b.push_back(a_b.pop_front()); pz = a_p.pop_front(); cl = a_c.pop_front(); end
            if (k == 0) c0 = cl;
            if (pz != (k < 4)) pbad++;
        end
        chk({b[1], b[0]} == 16'(evt), "R3", "header event number", {b[1], b[0]}, evt);
        chk({b[3], b[2]} == 16'(win), "R3", "header window field", {b[3], b[2]}, win);
        chk(pbad == 0, "R4", "header flag pattern errors", pbad, 0);
        chk(cl - c0 == n - 1, "R4", "contiguous strobe span", cl - c0, n - 1);
        for (int k = 0; k < win; k++) begin
            logic [31:0] w = {b[4+4*k+3], b[4+4*k+2], b[4+4*k+1], b[4+4*k]};
            chk(w == pat(first + k), rq, "payload sample", w, pat(first + k));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!a_we && !a_pause && !s_we && !s_pause, "R1", "strobes after reset",
            {a_we, a_pause, s_we, s_pause}, 0);
        chk(!a_busy && !s_busy, "R1", "busy after reset", {a_busy, s_busy}, 0);
        chk(a_drop == 0 && s_drop == 0, "R1", "drop count after reset", a_drop, 0);
    endtask

    task automatic t_single();
        int s, t;
        idle(80);
        tick(1, 0, t);
        tick(0, 0, s);
        expect_event(0, 0, t - DA, WA, "R2");
    endtask

    task automatic t_burst_and_drop();
        int t[4], s, t5, t6;
        for (int i = 0; i < 4; i++) tick(1, 0, t[i]);
        tick(0, 0, s);
        chk(a_busy, "R7", "busy with all slots taken", a_busy, 1);
        tick(1, 0, t5);
        tick(0, 0, s);
        chk(a_drop == 16'd1, "R7", "drop count after full trigger", a_drop, 1);
        expect_event(0, 1, t[0] - DA, WA, "R5");
        chk(!a_busy, "R8", "busy clears after oldest sent", a_busy, 0);
        tick(1, 0, t6);
        tick(0, 0, s);
        expect_event(0, 2, t[1] - DA, WA, "R6");
        expect_event(0, 3, t[2] - DA, WA, "R6");
        expect_event(0, 4, t[3] - DA, WA, "R5");
        expect_event(0, 5, t6 - DA, WA, "R8");
        idle(300);
        chk(a_b.size() == 0, "R7", "no event from dropped trigger", a_b.size(), 0);
        chk(a_drop == 16'd1, "R7", "drop count stable", a_drop, 1);
    endtask

    task automatic t_suppress();
        int s, t0, t1, t2;
        tick(0, 1, t0);
        tick(0, 0, s);
        expect_event(1, 0, t0, WS, "R9");
        tick(0, 1, t1);
        tick(0, 1, t2);
        tick(0, 0, s);
        expect_event(1, 1, t1, WS, "R9");
        expect_event(1, 2, t2, WS, "R9");
        chk(s_drop == 0, "R9", "no drops in suppress burst", s_drop, 0);
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(4);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_single();
        t_burst_and_drop();
        t_suppress();
        idle(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule